// File: doc/BRIEF.md
# Accumulator ALU with Jump Flag

This block performs one of eight arithmetic or logical operations on either an 8-bit or a 16-bit operand pair and reports a result, a write strobe and four condition flags: jump, zero, carry and half-carry. A caller presents the operation code, the width select, the operand form, the accumulator value, a register value, an immediate value and the current carry and half-carry flags with a one-cycle `start_i` pulse. The block latches these inputs and completes after a fixed number of cycles, which depends on the width and the form. It then raises `done_o` for one cycle with the registered outputs.

The operand form tells the block which value is the left operand and where the result goes. There are three forms: accumulator combined with a register into the accumulator, a register combined with the accumulator into that register, and a register combined with an immediate into that register. The register file, immediate fetch and instruction sequencing stay with the caller. The caller uses `dst_reg_o` and `wr_o` to decide where and whether to write `res_o`.

The jump flag is an extra condition output. For the arithmetic group it copies the new carry. For the logical group and compare it copies the new zero flag. Compare changes the flags but never asserts a write.

Top module: `alu_acc_top`

## Requirements
- R1: Operation codes on `op_i` are 0 add-with-carry, 1 add, 2 subtract-with-borrow, 3 subtract, 4 AND, 5 XOR, 6 OR, 7 compare. Compare computes left minus right with no incoming carry. The result appears on `res_o` while `done_o` is high.
- R2: Compare (code 7) updates the zero, carry, half-carry and jump flags, and `wr_o` stays low. For codes 0 to 6, `wr_o` is high in the `done_o` cycle.
- R3: For codes 0 to 3, `jf_o` equals the new `cf_o`.
- R4: For codes 4 to 7, `jf_o` equals the new `zf_o`.
- R5: Codes 4 to 6 copy the latched `cf_i` and `hf_i` to `cf_o` and `hf_o` unchanged.
- R6: The carry is the carry out of the active width for addition and the borrow for subtraction and compare. Codes 0 and 2 also add or subtract the latched `cf_i`.
- R7: In 8-bit mode, `hf_o` is the carry or borrow across bit 3 for codes 0 to 3 and 7. In 16-bit mode (`wide_i`=1), `hf_o` keeps the latched `hf_i`.
- R8: In 8-bit mode only bits 7:0 of the operands take part, and bits 15:8 of `res_o` are zero. `zf_o` is 1 exactly when the active-width result is zero.
- R9: `form_i` codes are 0 accumulator-destination, 1 register-destination and 2 immediate; code 3 behaves as 2. The latency L is 2 for 8-bit form 0, 3 for 8-bit forms 1 and 2, and 4 for any 16-bit form. `done_o` is high for exactly one cycle, L-1 rising edges after the edge that accepted `start_i`, and `busy_o` is high in between.
- R10: Operand routing follows the form. Form 0 computes acc op reg with `dst_reg_o`=0. Form 1 computes reg op acc with `dst_reg_o`=1. Form 2 computes reg op imm with `dst_reg_o`=1.
- R11: `start_i` is ignored while `busy_o` is high. The running operation completes with its own operands, and no extra `done_o` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation when idle |
| op_i | input | 3 | Operation code |
| wide_i | input | 1 | 1 selects 16-bit operands |
| form_i | input | 2 | Operand form and destination |
| acc_i | input | 16 | Accumulator value |
| reg_i | input | 16 | Register value |
| imm_i | input | 16 | Immediate value |
| cf_i | input | 1 | Incoming carry flag |
| hf_i | input | 1 | Incoming half-carry flag |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| wr_o | output | 1 | Result should be written back |
| dst_reg_o | output | 1 | 1 = register destination, 0 = accumulator |
| res_o | output | 16 | Result |
| jf_o | output | 1 | Jump flag |
| zf_o | output | 1 | Zero flag |
| cf_o | output | 1 | Carry flag |
| hf_o | output | 1 | Half-carry flag |

## Verification
A corrupted latched operand or operation code shows on `res_o` and the flags in the same `done_o` cycle. The bench checks that cycle against its own arithmetic model, with operand values chosen to produce carries, borrows, nibble crossings and zero results. A wrong countdown shows as `done_o` arriving one or more edges early or late, and each scenario measures that edge count directly. A second start that is wrongly accepted during `busy_o` shows as a changed result or a second `done_o` within a few cycles of the first.

// File: rtl/alu_acc_pkg.sv
package alu_acc_pkg;

    typedef enum logic [2:0] {
        OP_ADDC = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUBB = 3'd2,
        OP_SUB  = 3'd3,
        OP_AND  = 3'd4,
        OP_XOR  = 3'd5,
        OP_OR   = 3'd6,
        OP_CMP  = 3'd7
    } alu_op_e;

    localparam logic [1:0] FORM_ACC_DST = 2'd0;
    localparam logic [1:0] FORM_REG_DST = 2'd1;
    localparam logic [1:0] FORM_IMM     = 2'd2;

    localparam int LAT_W          = 3;
    localparam int LAT_NARROW_ACC = 2;
    localparam int LAT_NARROW_REG = 3;
    localparam int LAT_WIDE       = 4;

    function automatic logic [LAT_W-1:0] op_latency(input logic wide, input logic [1:0] form);
        if (wide)
            return LAT_W'(LAT_WIDE);
        else if (form == FORM_ACC_DST)
            return LAT_W'(LAT_NARROW_ACC);
        else
            return LAT_W'(LAT_NARROW_REG);
    endfunction

endpackage

// File: rtl/alu_acc_datapath.sv
module alu_acc_datapath
    import alu_acc_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op_i,
    input  logic           wide_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic           cin_i,
    input  logic           hin_i,
    output logic [W-1:0]   res_o,
    output logic           wr_o,
    output logic           jf_o,
    output logic           zf_o,
    output logic           cf_o,
    output logic           hf_o
);
    localparam int N   = W / 2;
    localparam int NIB = 4;

    logic [W:0]     ax, bx, sum, dif, raw;
    logic [NIB:0]   hsum, hdif;
    logic           cuse, is_add, is_logic, cy;

    always_comb begin
        ax       = wide_i ? {1'b0, a_i} : {{(N+1){1'b0}}, a_i[N-1:0]};
        bx       = wide_i ? {1'b0, b_i} : {{(N+1){1'b0}}, b_i[N-1:0]};
        cuse     = (op_i == OP_ADDC || op_i == OP_SUBB) && cin_i;
        is_add   = (op_i == OP_ADDC || op_i == OP_ADD);
        is_logic = (op_i == OP_AND || op_i == OP_XOR || op_i == OP_OR);
        sum      = ax + bx + {{W{1'b0}}, cuse};
        dif      = ax - bx - {{W{1'b0}}, cuse};
        hsum     = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, cuse};
        hdif     = {1'b0, a_i[NIB-1:0]} - {1'b0, b_i[NIB-1:0]} - {{NIB{1'b0}}, cuse};
        unique case (op_i)
            OP_ADDC, OP_ADD:          raw = sum;
            OP_SUBB, OP_SUB, OP_CMP:  raw = dif;
            OP_AND:                   raw = ax & bx;
            OP_XOR:                   raw = ax ^ bx;
            default:                  raw = ax | bx;
        endcase
        res_o = wide_i ? raw[W-1:0] : {{N{1'b0}}, raw[N-1:0]};
        cy    = wide_i ? raw[W] : raw[N];
        zf_o  = (res_o == '0);
        wr_o  = (op_i != OP_CMP);
        if (is_logic) begin
            cf_o = cin_i;
            hf_o = hin_i;
        end else begin
            cf_o = cy;
            hf_o = wide_i ? hin_i : (is_add ? hsum[NIB] : hdif[NIB]);
        end
        jf_o = (op_i <= OP_SUB) ? cf_o : zf_o;
    end

endmodule

// File: rtl/alu_acc_seq.sv
module alu_acc_seq
    import alu_acc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LAT_W-1:0] lat_i,
    output logic             accept_o,
    output logic             busy_o,
    output logic             fin_o
);
    typedef struct packed {
        logic             busy;
        logic [LAT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        accept_o = start_i && !s_q.busy;
        fin_o    = s_q.busy && (s_q.cnt == LAT_W'(1));
        if (accept_o) begin
            s_d.busy = 1'b1;
            s_d.cnt  = lat_i - LAT_W'(1);
        end else if (fin_o) begin
            s_d.busy = 1'b0;
            s_d.cnt  = '0;
        end else if (s_q.busy) begin
            s_d.cnt  = s_q.cnt - LAT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o = s_q.busy;

    // R9: an active countdown never reaches zero
    assert_cnt_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.cnt != '0));

endmodule

// File: rtl/alu_acc_top.sv
module alu_acc_top
    import alu_acc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [2:0]   op_i,
    input  logic         wide_i,
    input  logic [1:0]   form_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] reg_i,
    input  logic [W-1:0] imm_i,
    input  logic         cf_i,
    input  logic         hf_i,
    output logic         busy_o,
    output logic         done_o,
    output logic         wr_o,
    output logic         dst_reg_o,
    output logic [W-1:0] res_o,
    output logic         jf_o,
    output logic         zf_o,
    output logic         cf_o,
    output logic         hf_o
);
    typedef struct packed {
        alu_op_e          op;
        logic             wide;
        logic [W-1:0]     a;
        logic [W-1:0]     b;
        logic             dst_reg;
        logic             cin;
        logic             hin;
        logic [LAT_W-1:0] lat;
        logic [LAT_W-1:0] age;
        logic [W-1:0]     res;
        logic             wr;
        logic             done;
        logic             jf, zf, cf, hf;
    } top_t;

    top_t t_d, t_q;

    logic             accept, fin, busy;
    logic [W-1:0]     dp_res;
    logic             dp_wr, dp_jf, dp_zf, dp_cf, dp_hf;

    alu_acc_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .lat_i    (op_latency(wide_i, form_i)),
        .accept_o (accept),
        .busy_o   (busy),
        .fin_o    (fin)
    );

    alu_acc_datapath #(.W(W)) u_dp (
        .op_i   (t_q.op),
        .wide_i (t_q.wide),
        .a_i    (t_q.a),
        .b_i    (t_q.b),
        .cin_i  (t_q.cin),
        .hin_i  (t_q.hin),
        .res_o  (dp_res),
        .wr_o   (dp_wr),
        .jf_o   (dp_jf),
        .zf_o   (dp_zf),
        .cf_o   (dp_cf),
        .hf_o   (dp_hf)
    );

    always_comb begin
        t_d      = t_q;
        t_d.done = 1'b0;
        t_d.wr   = 1'b0;
        if (busy) t_d.age = t_q.age + LAT_W'(1);
        if (accept) begin
            t_d.op   = alu_op_e'(op_i);
            t_d.wide = wide_i;
            t_d.cin  = cf_i;
            t_d.hin  = hf_i;
            t_d.lat  = op_latency(wide_i, form_i);
            t_d.age  = '0;
            unique case (form_i)
                FORM_ACC_DST: begin t_d.a = acc_i; t_d.b = reg_i; t_d.dst_reg = 1'b0; end
                FORM_REG_DST: begin t_d.a = reg_i; t_d.b = acc_i; t_d.dst_reg = 1'b1; end
                default:      begin t_d.a = reg_i; t_d.b = imm_i; t_d.dst_reg = 1'b1; end
            endcase
        end else if (fin) begin
            t_d.res  = dp_res;
            t_d.wr   = dp_wr;
            t_d.done = 1'b1;
            t_d.jf   = dp_jf;
            t_d.zf   = dp_zf;
            t_d.cf   = dp_cf;
            t_d.hf   = dp_hf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy_o    = busy;
    assign done_o    = t_q.done;
    assign wr_o      = t_q.wr;
    assign dst_reg_o = t_q.dst_reg;
    assign res_o     = t_q.res;
    assign jf_o      = t_q.jf;
    assign zf_o      = t_q.zf;
    assign cf_o      = t_q.cf;
    assign hf_o      = t_q.hf;

    // R2: compare never requests a write
    assert_cmp_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && t_q.op == OP_CMP) |-> !wr_o);
    // R2: write strobe only with completion
    assert_wr_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> done_o);
    // R3: arithmetic jump flag follows carry
    assert_jf_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && t_q.op <= OP_SUB) |-> (jf_o == cf_o));
    // R4: logical and compare jump flag follows zero
    assert_jf_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && t_q.op >= OP_AND) |-> (jf_o == zf_o));
    // R5: logical operations keep carry and half-carry
    assert_logic_keeps_cf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && t_q.op >= OP_AND && t_q.op != OP_CMP) |-> (cf_o == t_q.cin && hf_o == t_q.hin));
    // R9: completion arrives after the latched latency
    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (t_q.age == t_q.lat - LAT_W'(1)));
    // R9: completion is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R11: start during busy leaves latched operation untouched
    assert_busy_ignores_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(t_q.op) && $stable(t_q.a) && $stable(t_q.b)));

endmodule

// File: tb/alu_acc_top_tb.sv
module alu_acc_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic        wide_i = 1'b0;
    logic [1:0]  form_i = '0;
    logic [15:0] acc_i = '0, reg_i = '0, imm_i = '0;
    logic        cf_i = 1'b0, hf_i = 1'b0;
    logic        busy_o, done_o, wr_o, dst_reg_o;
    logic [15:0] res_o;
    logic        jf_o, zf_o, cf_o, hf_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    alu_acc_top u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .wide_i(wide_i),
        .form_i(form_i), .acc_i(acc_i), .reg_i(reg_i), .imm_i(imm_i), .cf_i(cf_i),
        .hf_i(hf_i), .busy_o(busy_o), .done_o(done_o), .wr_o(wr_o), .dst_reg_o(dst_reg_o),
        .res_o(res_o), .jf_o(jf_o), .zf_o(zf_o), .cf_o(cf_o), .hf_o(hf_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // independent reference model
    task automatic model(input int op, input bit wide, input int a, input int b,
                         input bit cin, input bit hin,
                         output int res, output bit jf, output bit zf,
                         output bit cf, output bit hf, output bit wr);
        int m, ai, bi, c, t;
        m  = wide ? 65535 : 255;
        ai = a & m;
        bi = b & m;
        c  = (op == 0 || op == 2) ? int'(cin) : 0;
        cf = cin;
        hf = hin;
        if (op <= 1) begin
            t   = ai + bi + c;
            res = t & m;
            cf  = (t > m);
            if (!wide) hf = ((ai & 15) + (bi & 15) + c) > 15;
        end else if (op == 2 || op == 3 || op == 7) begin
            t   = ai - bi - c;
            res = t & m;
            cf  = (t < 0);
            if (!wide) hf = ((ai & 15) - (bi & 15) - c) < 0;
        end else if (op == 4) res = ai & bi;
        else if (op == 5)     res = ai ^ bi;
        else                  res = ai | bi;
        zf = (res == 0);
        jf = (op <= 3) ? cf : zf;
        wr = (op != 7);
    endtask

    task automatic run_op(input string tag, input int op, input bit wide, input int form,
                          input int acc, input int rg, input int imm,
                          input bit cin, input bit hin);
        int a, b, eres, lat, n;
        bit ejf, ezf, ecf, ehf, ewr, edst;
        a    = (form == 0) ? acc : rg;
        b    = (form == 0) ? rg : ((form == 1) ? acc : imm);
        edst = (form != 0);
        lat  = wide ? 4 : ((form == 0) ? 2 : 3);
        model(op, wide, a, b, cin, hin, eres, ejf, ezf, ecf, ehf, ewr);
        @(negedge clk);
        op_i = 3'(op); wide_i = wide; form_i = 2'(form);
        acc_i = 16'(acc); reg_i = 16'(rg); imm_i = 16'(imm);
        cf_i = cin; hf_i = hin; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 1;
        chk({tag, " R9 busy"}, int'(busy_o || done_o), 1);
        while (!done_o && n < 10) begin
            @(negedge clk);
            if (!done_o) n++;
        end
        chk({tag, " R9 latency"}, n, lat - 1);
        chk({tag, " R1 R8 result"}, int'(res_o), eres);
        chk({tag, " R2 write"}, int'(wr_o), int'(ewr));
        chk({tag, " R10 dest"}, int'(dst_reg_o), int'(edst));
        chk({tag, " R3 R4 jf"}, int'(jf_o), int'(ejf));
        chk({tag, " R8 zf"}, int'(zf_o), int'(ezf));
        chk({tag, " R5 R6 cf"}, int'(cf_o), int'(ecf));
        chk({tag, " R7 hf"}, int'(hf_o), int'(ehf));
        @(negedge clk);
        chk({tag, " R9 done pulse"}, int'(done_o), 0);
    endtask

    task automatic t_reset;
        chk("reset busy", int'(busy_o), 0);
        chk("reset done", int'(done_o), 0);
        chk("reset wr", int'(wr_o), 0);
        chk("reset res", int'(res_o), 0);
    endtask

    task automatic t_add_group;
        run_op("R1 add nibble", 1, 0, 0, 'h3A, 'h0C, 0, 1, 0);
        run_op("R6 addc wrap", 0, 0, 0, 'hFF, 'h00, 0, 1, 0);
        run_op("R6 addc no cin", 0, 0, 1, 'h11, 'h22, 0, 0, 1);
    endtask

    task automatic t_sub_group;
        run_op("R6 sub halfborrow", 3, 0, 1, 'h01, 'h10, 0, 0, 0);
        run_op("R6 sub borrow", 3, 0, 2, 0, 'h05, 'h06, 0, 0);
        run_op("R6 subb cin", 2, 0, 0, 'h20, 'h1F, 0, 1, 0);
    endtask

    task automatic t_logic_group;
        run_op("R5 and zero", 4, 0, 2, 0, 'hF0, 'h0F, 1, 1);
        run_op("R5 xor", 5, 0, 1, 'h5A, 'h3C, 0, 1, 0);
        run_op("R5 or", 6, 0, 0, 'h80, 'h01, 0, 0, 1);
    endtask

    task automatic t_compare;
        run_op("R2 cmp equal", 7, 0, 2, 0, 'h42, 'h42, 1, 1);
        run_op("R2 cmp less", 7, 0, 0, 'h10, 'h11, 0, 0, 0);
    endtask

    task automatic t_wide;
        run_op("R7 wide add carry", 1, 1, 0, 'hFFFF, 'h0001, 0, 0, 1);
        run_op("R7 wide sub", 3, 1, 2, 0, 'h1000, 'h0001, 0, 0);
        run_op("R8 wide or", 6, 1, 1, 'h1200, 'h0034, 0, 1, 0);
    endtask

    task automatic t_narrow_upper;
        run_op("R8 upper ignored", 1, 0, 0, 'hAB12, 'hCD00, 0, 0, 0);
    endtask

    task automatic t_busy_ignore;
        int n, extra;
        @(negedge clk);
        op_i = 3'd1; wide_i = 1'b1; form_i = 2'd0;
        acc_i = 16'h0100; reg_i = 16'h0023; imm_i = 16'h0; cf_i = 0; hf_i = 0;
        start_i = 1'b1;
        @(negedge clk);
        op_i = 3'd4; acc_i = 16'h0000; reg_i = 16'hFFFF;
        @(negedge clk);
        start_i = 1'b0;
        n = 2;
        while (!done_o && n < 10) begin
            @(negedge clk);
            if (!done_o) n++;
        end
        chk("R11 latency kept", n, 3);
        chk("R11 result kept", int'(res_o), 'h0123);
        extra = 0;
        repeat (6) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        chk("R11 no second done", extra, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_add_group();
        t_sub_group();
        t_logic_group();
        t_compare();
        t_wide();
        t_narrow_upper();
        t_busy_ignore();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule